// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order retirement store of an out-of-order core. Instructions enter it in program order at issue. Each one claims a slot in a circular ring. The slot keeps the instruction kind, the destination (a register number or a store address) and, later, the result value. The slot number goes back to the issue logic as the tag that names the result while it is in flight.

When a functional unit finishes, it places the tag and the value on the shared result bus. The matching slot captures the value and is marked complete. Until it retires, a completed slot can answer operand lookups by tag, so dependent instructions can read a speculative result before it is committed. Retirement happens only from the oldest slot and only when that slot holds its result. The slot then drives a register write or a memory store and is freed.

A branch found mispredicted at retirement discards every slot. So does an instruction that carries an exception flag. The exception flag becomes visible only when its instruction is the oldest, which keeps exceptions precise. Reservation stations, execution units and the architectural register file sit outside this block.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `cm_valid`=0.
- R2: `alloc_grant` is 1 only when `alloc_req` and `rs_free` are both 1, the buffer is not full and no flush is signalled in that cycle. Granted tags start at 0 and increase by one per grant, wrapping modulo the depth (16).
- R3: After 16 grants with no retirement, `full`=1 and further requests are refused.
- R4: A result-bus write (`cdb_valid` with `cdb_tag`) marks that slot complete. From the next cycle on, a lookup of that tag returns `lk_ready`=1 and the written value. Before the write, the lookup returns `lk_ready`=0.
- R5: `cm_valid` is 1 only while the oldest slot is complete. Completed younger slots wait, and slots retire in allocation order, one per cycle.
- R6: Kind encodings are 0 = register result, 1 = store, 2 = branch. A retiring kind-0 slot raises `cm_reg_we` and a kind-1 slot raises `cm_mem_we`, each with `cm_dest` and `cm_value` taken from that slot. A retiring branch that was not mispredicted raises neither and does not flush.
- R7: A grant and a retirement in the same cycle leave the occupancy unchanged.
- R8: A retiring branch whose completion carried `cdb_mispredict`=1 raises `flush` in that cycle with no write enable and no grant. From the next cycle the buffer is empty, all lookups read not ready and the next tag is 0.
- R9: An exception flag written with a result shows on `cm_exc` only when that slot retires. That retirement suppresses both write enables and flushes the buffer like R8.
- R10: A lookup of a slot that holds no live instruction returns `lk_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Issue logic asks for a slot |
| alloc_kind | input | 2 | Kind of the issuing instruction |
| alloc_dest | input | DEST_W | Destination register or store address |
| rs_free | input | 1 | A reservation station is available |
| alloc_grant | output | 1 | Slot granted this cycle |
| alloc_tag | output | IDX_W | Tag of the granted slot |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| cdb_valid | input | 1 | Result bus carries a completion |
| cdb_tag | input | IDX_W | Slot that completed |
| cdb_value | input | DATA_W | Result value |
| cdb_exc | input | 1 | Completion raised an exception |
| cdb_mispredict | input | 1 | Completing branch was mispredicted |
| lk_tag | input | IDX_W | Operand lookup tag |
| lk_ready | output | 1 | Looked-up slot holds a result |
| lk_value | output | DATA_W | Looked-up result (0 when not ready) |
| cm_valid | output | 1 | Oldest slot retires this cycle |
| cm_kind | output | 2 | Kind of the retiring slot |
| cm_dest | output | DEST_W | Destination of the retiring slot |
| cm_value | output | DATA_W | Value of the retiring slot |
| cm_exc | output | 1 | Retiring slot carries an exception |
| cm_reg_we | output | 1 | Register-file write strobe |
| cm_mem_we | output | 1 | Memory store strobe |
| flush | output | 1 | Buffer discarded at the next edge |

## Verification
Grants, retirement outputs and flush are combinational on the current state. They are due in the same cycle as the request, or as soon as the oldest slot becomes complete. A result-bus write, an allocation, a retirement or a flush shows up one clock edge later, in lookups, tags and occupancy. The bench drives inputs just after the falling edge and samples one time unit later, so it reads each combinational answer within its cycle. It reads registered effects only after the next rising edge has passed. The sequences place a younger slot completing before the oldest, an exception set on a younger slot, a full ring with and without retirement, and a mispredicted branch between live results, so that each of these cycle counts is tested.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             retire,
  input  logic             flush,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full,
  output logic             empty
);
  logic [IDX_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    head_n = head;
    tail_n = tail;
    cnt_n  = cnt;
    if (flush) begin
      head_n = '0;
      tail_n = '0;
      cnt_n  = '0;
    end else begin
      if (grant)  tail_n = tail + 1'b1;
      if (retire) head_n = head + 1'b1;
      case ({grant, retire})
        2'b10:   cnt_n = cnt + 1'b1;
        2'b01:   cnt_n = cnt - 1'b1;
        default: cnt_n = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      head <= head_n;
      tail <= tail_n;
      cnt  <= cnt_n;
    end
  end

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/rob_slot.sv
module rob_slot #(
  parameter int DATA_W = 32,
  parameter int DEST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              wb_en,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_exc,
  input  logic              wb_misp,
  input  logic              free_en,
  output logic              valid,
  output logic              ready,
  output logic [1:0]        kind,
  output logic [DEST_W-1:0] dest,
  output logic [DATA_W-1:0] value,
  output logic              exc,
  output logic              misp
);
  logic valid_n, ready_n;

  always_comb begin
    valid_n = valid;
    ready_n = ready;
    if (free_en) begin
      valid_n = 1'b0;
      ready_n = 1'b0;
    end
    if (alloc_en) begin
      valid_n = 1'b1;
      ready_n = 1'b0;
    end
    if (wb_en) ready_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      ready <= 1'b0;
    end else begin
      valid <= valid_n;
      ready <= ready_n;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      kind <= alloc_kind;
      dest <= alloc_dest;
    end
    if (wb_en) begin
      value <= wb_value;
      exc   <= wb_exc;
      misp  <= wb_misp;
    end
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              rs_free,
  output logic              alloc_grant,
  output logic [IDX_W-1:0]  alloc_tag,
  output logic              full,
  output logic              empty,
  input  logic              cdb_valid,
  input  logic [IDX_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_exc,
  input  logic              cdb_mispredict,
  input  logic [IDX_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value,
  output logic              cm_valid,
  output logic [1:0]        cm_kind,
  output logic [DEST_W-1:0] cm_dest,
  output logic [DATA_W-1:0] cm_value,
  output logic              cm_exc,
  output logic              cm_reg_we,
  output logic              cm_mem_we,
  output logic              flush
);
  import rob_pkg::*;

  logic [DEPTH-1:0]  s_valid, s_ready, s_exc, s_misp;
  logic [1:0]        s_kind  [DEPTH];
  logic [DEST_W-1:0] s_dest  [DEPTH];
  logic [DATA_W-1:0] s_value [DEPTH];
  logic [IDX_W-1:0]  head, tail;
  logic              retire, head_done, squash;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .grant(alloc_grant), .retire(retire),
    .flush(flush), .head(head), .tail(tail), .full(full), .empty(empty)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic a_en, w_en, f_en;
    assign a_en = alloc_grant && (tail == IDX_W'(i));
    assign w_en = cdb_valid && (cdb_tag == IDX_W'(i)) && s_valid[i];
    assign f_en = flush || (retire && (head == IDX_W'(i)));
    rob_slot #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(a_en), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
      .wb_en(w_en), .wb_value(cdb_value), .wb_exc(cdb_exc), .wb_misp(cdb_mispredict),
      .free_en(f_en),
      .valid(s_valid[i]), .ready(s_ready[i]), .kind(s_kind[i]), .dest(s_dest[i]),
      .value(s_value[i]), .exc(s_exc[i]), .misp(s_misp[i])
    );
  end

  // retirement from the oldest slot
  assign head_done = s_valid[head] && s_ready[head];
  assign retire    = !empty && head_done;
  assign cm_valid  = retire;
  assign cm_kind   = s_kind[head];
  assign cm_dest   = s_dest[head];
  assign cm_value  = s_value[head];
  assign cm_exc    = retire && s_exc[head];
  assign squash    = s_exc[head] || ((s_kind[head] == KIND_BRANCH) && s_misp[head]);
  assign flush     = retire && squash;
  assign cm_reg_we = retire && !squash && (s_kind[head] == KIND_REG);
  assign cm_mem_we = retire && !squash && (s_kind[head] == KIND_STORE);

  // issue side
  assign alloc_grant = alloc_req && rs_free && !full && !flush;
  assign alloc_tag   = tail;

  // operand lookup of speculative results
  assign lk_ready = s_valid[lk_tag] && s_ready[lk_tag];
  assign lk_value = lk_ready ? s_value[lk_tag] : '0;
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_grant,
  input logic [IDX_W-1:0] alloc_tag,
  input logic             full,
  input logic             empty,
  input logic             cm_valid,
  input logic             cm_exc,
  input logic             cm_reg_we,
  input logic             cm_mem_we,
  input logic             flush
);
  a_r1_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r2_tag_steps: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> (alloc_tag == $past(alloc_tag) + 1'b1));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cm_valid) |=> full);

  a_r5_no_retire_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !cm_valid);

  a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_reg_we, cm_mem_we, flush}));

  a_r7_occupancy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && alloc_grant) |=> (full == $past(full)) && (empty == $past(empty)));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  a_r9_exc_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
    cm_exc |-> (cm_valid && flush && !cm_reg_we && !cm_mem_we));
endmodule

bind spec_rob rob_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_grant(alloc_grant), .alloc_tag(alloc_tag),
  .full(full), .empty(empty), .cm_valid(cm_valid), .cm_exc(cm_exc),
  .cm_reg_we(cm_reg_we), .cm_mem_we(cm_mem_we), .flush(flush)
);

// File: tb/spec_rob_tb.sv
module spec_rob_tb;
  localparam int CLK_P = 10;
  localparam logic [1:0] K_REG = 2'd0, K_ST = 2'd1, K_BR = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_req = 0, rs_free = 0, cdb_valid = 0, cdb_exc = 0, cdb_misp = 0;
  logic [1:0] alloc_kind = 0;
  logic [7:0] alloc_dest = 0;
  logic [3:0] cdb_tag = 0, lk_tag = 0;
  logic [31:0] cdb_value = 0;
  logic alloc_grant, full, empty, lk_ready, cm_valid, cm_exc, cm_reg_we, cm_mem_we, flush;
  logic [3:0] alloc_tag;
  logic [31:0] lk_value, cm_value;
  logic [1:0] cm_kind;
  logic [7:0] cm_dest;
  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  spec_rob u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .rs_free(rs_free), .alloc_grant(alloc_grant),
    .alloc_tag(alloc_tag), .full(full), .empty(empty), .cdb_valid(cdb_valid),
    .cdb_tag(cdb_tag), .cdb_value(cdb_value), .cdb_exc(cdb_exc),
    .cdb_mispredict(cdb_misp), .lk_tag(lk_tag), .lk_ready(lk_ready),
    .lk_value(lk_value), .cm_valid(cm_valid), .cm_kind(cm_kind), .cm_dest(cm_dest),
    .cm_value(cm_value), .cm_exc(cm_exc), .cm_reg_we(cm_reg_we),
    .cm_mem_we(cm_mem_we), .flush(flush)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] d, input logic [3:0] exp_tag);
    alloc_req = 1; rs_free = 1; alloc_kind = k; alloc_dest = d;
    #1;
    chk("R2 grant", alloc_grant, 1);
    chk("R2 tag", alloc_tag, exp_tag);
    @(negedge clk);
    alloc_req = 0;
    #1;
  endtask

  task automatic wb(input logic [3:0] t, input logic [31:0] v, input logic e, input logic m);
    cdb_valid = 1; cdb_tag = t; cdb_value = v; cdb_exc = e; cdb_misp = m;
    @(negedge clk);
    cdb_valid = 0; cdb_exc = 0; cdb_misp = 0;
    #1;
  endtask

  task automatic expect_retire(input string req, input logic [1:0] k, input logic [7:0] d,
                               input logic [31:0] v);
    chk({req, " cm_valid"}, cm_valid, 1);
    chk({req, " kind"}, cm_kind, k);
    chk({req, " dest"}, cm_dest, d);
    chk({req, " value"}, cm_value, v);
    chk({req, " reg_we"}, cm_reg_we, k == K_REG);
    chk({req, " mem_we"}, cm_mem_we, k == K_ST);
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 cm_valid", cm_valid, 0);
    lk_tag = 0; #1;
    chk("R10 lookup free slot", lk_ready, 0);
  endtask

  task automatic t_basic();
    alloc_req = 1; rs_free = 0; #1;
    chk("R2 no station no grant", alloc_grant, 0);
    step(); alloc_req = 0;
    issue(K_REG, 8'h11, 4'd0);
    issue(K_REG, 8'h22, 4'd1);
    issue(K_REG, 8'h33, 4'd2);
    lk_tag = 1; #1;
    chk("R4 not yet written", lk_ready, 0);
    wb(2, 32'hC0DE0002, 0, 0);
    chk("R5 younger waits", cm_valid, 0);
    lk_tag = 2; #1;
    chk("R4 lookup ready", lk_ready, 1);
    chk("R4 lookup value", lk_value, 32'hC0DE0002);
    wb(0, 32'hA0, 0, 0);
    expect_retire("R6 reg retire", K_REG, 8'h11, 32'hA0);
    step();
    chk("R5 head not ready", cm_valid, 0);
    wb(1, 32'hB1, 0, 0);
    expect_retire("R5 order 1", K_REG, 8'h22, 32'hB1);
    step();
    expect_retire("R5 order 2", K_REG, 8'h33, 32'hC0DE0002);
    step();
    chk("R5 drained", empty, 1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) issue(K_ST, 8'h40 + 8'(i), 4'((3 + i) % 16));
    chk("R3 full", full, 1);
    alloc_req = 1; rs_free = 1; #1;
    chk("R3 refused when full", alloc_grant, 0);
    alloc_req = 0;
    wb(3, 32'h1000, 0, 0);
    expect_retire("R6 store retire", K_ST, 8'h40, 32'h1000);
    alloc_req = 1; #1;
    chk("R3 full until edge", alloc_grant, 0);
    alloc_req = 0;
    step();
    chk("R3 one slot freed", full, 0);
    wb(6, 32'hDEAD, 1, 0);
    chk("R9 exc hidden young", cm_exc, 0);
    chk("R9 no retire young", cm_valid, 0);
    wb(4, 32'h1004, 0, 0);
    alloc_req = 1; alloc_kind = K_ST; alloc_dest = 8'h60; #1;
    chk("R7 grant with retire", alloc_grant, 1);
    chk("R7 tag", alloc_tag, 3);
    chk("R7 retire", cm_valid, 1);
    @(negedge clk); alloc_req = 0; #1;
    chk("R7 occupancy kept", full, 0);
    issue(K_ST, 8'h61, 4'd4);
    chk("R7 count reaches full", full, 1);
    wb(5, 32'h1005, 0, 0);
    expect_retire("R6 store retire 2", K_ST, 8'h42, 32'h1005);
    step();
    chk("R9 cm_exc", cm_exc, 1);
    chk("R9 flush", flush, 1);
    chk("R9 no store", cm_mem_we, 0);
    step();
    chk("R9 empty after", empty, 1);
    lk_tag = 7; #1;
    chk("R10 flushed slot", lk_ready, 0);
  endtask

  task automatic t_branch();
    issue(K_REG, 8'h11, 4'd0);
    issue(K_BR, 8'h00, 4'd1);
    issue(K_REG, 8'h13, 4'd2);
    wb(2, 32'h22, 0, 0);
    wb(1, 32'h0, 0, 1);
    wb(0, 32'h77, 0, 0);
    expect_retire("R6 reg before branch", K_REG, 8'h11, 32'h77);
    step();
    alloc_req = 1; rs_free = 1; #1;
    chk("R8 flush", flush, 1);
    chk("R8 no reg write", cm_reg_we, 0);
    chk("R8 no store", cm_mem_we, 0);
    chk("R8 no grant", alloc_grant, 0);
    alloc_req = 0;
    step();
    chk("R8 empty", empty, 1);
    lk_tag = 2; #1;
    chk("R8 lookup cleared", lk_ready, 0);
    issue(K_BR, 8'h00, 4'd0);
    wb(0, 32'h0, 0, 0);
    chk("R6 good branch retires", cm_valid, 1);
    chk("R6 good branch no flush", flush, 0);
    chk("R6 good branch no reg", cm_reg_we, 0);
    chk("R6 good branch no mem", cm_mem_we, 0);
    step();
    chk("R6 branch drained", empty, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_fill();
    t_branch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule